// File: doc/BRIEF.md
# Operand-Routing Accumulate Unit with Private Register Bank

This unit sits next to a processor core and executes one arithmetic instruction at a time over a multi-cycle handshake. It also owns a private bank of 32 registers, each 32 bits wide. Three routing flags come with every issue.

- Each of the two operand flags picks where that operand comes from. The operand is either the value the core presents on its data port or the content of a private register, selected by a 5-bit index.
- The third flag directs the sum into a private register chosen by a third 5-bit index. The core then discards the returned value.

The operation is a wrapping 32-bit addition. The core raises `start` for one enabled edge, and the unit captures the flags, the indices and both data words on that edge. The unit answers with a one-cycle `done` pulse. The result is presented in that same cycle. A clock qualifier `ce` freezes every register while it is low. A synchronous, active-high reset clears the bank and the outputs.

Top module: `ci_lrf_unit`

## Requirements
- R1: A reset edge drives `done` and `res` to 0 and clears all 32 private registers, so any register read through a local operand afterwards contributes 0.
- R2: With `ext_a` = 1 the first operand is the `opnd_a` word captured at the issue edge.
- R3: With `ext_a` = 0 the first operand is the private register selected by `idx_a`.
- R4: The second operand follows the same rule through `ext_b`, `opnd_b` and `idx_b`: external when the flag is 1 and private when it is 0.
- R5: With `keep_local` = 1 the sum is written into the private register selected by `idx_c`, and `res` still shows the same sum.
- R6: With `keep_local` = 0 no private register changes, whatever `idx_c` holds.
- R7: An index whose operand flag is 1 has no effect on the result.
- R8: Flags, indices and data words are sampled only on the issue edge. Any change to them while the instruction executes has no effect.
- R9: While `ce` is low, clock edges are ignored. `start` is not accepted, and `done`, `res` and the private registers hold their values.
- R10: `done` rises after the second enabled edge counted from the issue edge and stays high for exactly one enabled cycle. `res` carries (A + B) mod 2^32 from that cycle until the next completion.
- R11: When one instruction both reads and writes the same private register, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset, acts regardless of `ce` |
| ce | input | 1 | Clock qualifier; edges with `ce` low are ignored |
| start | input | 1 | Issue strobe, sampled on an enabled edge while idle |
| ext_a | input | 1 | 1: first operand from `opnd_a`; 0: from private register `idx_a` |
| ext_b | input | 1 | 1: second operand from `opnd_b`; 0: from private register `idx_b` |
| keep_local | input | 1 | 1: write the sum into private register `idx_c` |
| idx_a | input | 5 | Private register index for the first operand |
| idx_b | input | 5 | Private register index for the second operand |
| idx_c | input | 5 | Private register index for the write-back |
| opnd_a | input | 32 | External first operand |
| opnd_b | input | 32 | External second operand |
| done | output | 1 | One-cycle completion pulse |
| res | output | 32 | Sum, valid while `done` is high and held afterwards |

## Verification
The embedded properties assume that the core never raises `start` while an instruction is still executing. Every issue in the stimulus waits until the previous `done` has been seen, and `start` drops right after the issue edge. All inputs change only on falling edges, so the unit sees stable values at every rising edge. During execution the stimulus deliberately scrambles flags, indices and data, and it leaves `ce` low for stretches both before an issue and in the middle of one. That exercises the capture and stall rules without breaking the issue assumption.

// File: rtl/ci_lrf_pkg.sv
`timescale 1ns/1ps
package ci_lrf_pkg;

    // Per-instruction routing of both operands and of the result.
    typedef struct packed {
        logic src_ext_a;   // first operand taken from the core
        logic src_ext_b;   // second operand taken from the core
        logic dst_local;   // sum kept in the private bank
    } route_t;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_EXEC = 1'b1
    } phase_e;

    function automatic route_t make_route(input logic ea, input logic eb, input logic wb);
        route_t r;
        r.src_ext_a = ea;
        r.src_ext_b = eb;
        r.dst_local = wb;
        return r;
    endfunction

endpackage

// File: rtl/ci_lrf_seq.sv
`timescale 1ns/1ps
module ci_lrf_seq
    import ci_lrf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce,
    input  logic              start,
    input  route_t            route_i,
    input  logic [IDX_W-1:0]  ia_i,
    input  logic [IDX_W-1:0]  ib_i,
    input  logic [IDX_W-1:0]  ic_i,
    input  logic [DATA_W-1:0] da_i,
    input  logic [DATA_W-1:0] db_i,
    output route_t            route_q,
    output logic [IDX_W-1:0]  ia_q,
    output logic [IDX_W-1:0]  ib_q,
    output logic [IDX_W-1:0]  ic_q,
    output logic [DATA_W-1:0] da_q,
    output logic [DATA_W-1:0] db_q,
    output logic              exec_o,
    output logic              fire_o
);

    phase_e ph;
    logic   accept;

    assign accept = ce && start && (ph == PH_IDLE);
    assign exec_o = (ph == PH_EXEC);
    assign fire_o = exec_o && ce;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph      <= PH_IDLE;
            route_q <= '0;
            ia_q    <= '0;
            ib_q    <= '0;
            ic_q    <= '0;
            da_q    <= '0;
            db_q    <= '0;
        end else if (ce) begin
            unique case (ph)
                PH_IDLE: begin
                    if (accept) begin
                        ph      <= PH_EXEC;
                        route_q <= route_i;
                        ia_q    <= ia_i;
                        ib_q    <= ib_i;
                        ic_q    <= ic_i;
                        da_q    <= da_i;
                        db_q    <= db_i;
                    end
                end
                PH_EXEC: ph <= PH_IDLE;
                default: ph <= PH_IDLE;
            endcase
        end
    end

    AST_STALL_KEEPS_EXEC: assert property (@(posedge clk) disable iff (rst)
        (exec_o && !ce) |=> exec_o) else $error("stalled instruction lost"); // R9

    AST_FIELDS_FROZEN: assert property (@(posedge clk) disable iff (rst)
        exec_o |=> ($stable(route_q) && $stable(ia_q) && $stable(ib_q) && $stable(ic_q)
                    && $stable(da_q) && $stable(db_q))) else $error("captured fields moved"); // R8

    AST_NO_ISSUE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (ce && start) |-> !exec_o) else $error("issue while executing"); // R8

    AST_SINGLE_FIRE: assert property (@(posedge clk) disable iff (rst)
        fire_o |=> !exec_o) else $error("execution longer than one enabled cycle"); // R10

endmodule

// File: rtl/ci_lrf_bank.sv
`timescale 1ns/1ps
module ci_lrf_bank #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ra,
    input  logic [IDX_W-1:0]  rb,
    output logic [DATA_W-1:0] rda,
    output logic [DATA_W-1:0] rdb
);

    localparam int NREG = 1 << IDX_W;

    logic [NREG-1:0][DATA_W-1:0] mem;
    logic [NREG-1:0]             wsel;

    for (genvar g = 0; g < NREG; g++) begin : g_wdec
        assign wsel[g] = we && (waddr == IDX_W'(g));
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < NREG; k++) begin
            if (rst)          mem[k] <= '0;
            else if (wsel[k]) mem[k] <= wdata;
        end
    end

    // Reads see the content before a same-cycle write.
    assign rda = mem[ra];
    assign rdb = mem[rb];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        we |=> (mem[$past(waddr)] == $past(wdata))) else $error("write lost"); // R5

    AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(mem)) else $error("bank changed without write"); // R6

endmodule

// File: rtl/ci_lrf_exec.sv
`timescale 1ns/1ps
module ci_lrf_exec
    import ci_lrf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce,
    input  logic              fire,
    input  route_t            route,
    input  logic [DATA_W-1:0] da,
    input  logic [DATA_W-1:0] db,
    input  logic [DATA_W-1:0] la,
    input  logic [DATA_W-1:0] lb,
    output logic [DATA_W-1:0] sum,
    output logic [DATA_W-1:0] res_q,
    output logic              done_q
);

    logic [DATA_W-1:0] op_a;
    logic [DATA_W-1:0] op_b;

    assign op_a = route.src_ext_a ? da : la;
    assign op_b = route.src_ext_b ? db : lb;
    assign sum  = op_a + op_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= '0;
            done_q <= 1'b0;
        end else if (ce) begin
            done_q <= fire;
            if (fire) res_q <= sum;
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (done_q && ce) |=> !done_q) else $error("done longer than one cycle"); // R10

    AST_STALL_HOLDS_OUT: assert property (@(posedge clk) disable iff (rst)
        !ce |=> ($stable(done_q) && $stable(res_q))) else $error("output moved while stalled"); // R9

    AST_RES_ONLY_ON_FIRE: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(res_q)) else $error("result changed without completion"); // R10

endmodule

// File: rtl/ci_lrf_unit.sv
`timescale 1ns/1ps
module ci_lrf_unit
    import ci_lrf_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce,
    input  logic              start,
    input  logic              ext_a,
    input  logic              ext_b,
    input  logic              keep_local,
    input  logic [IDX_W-1:0]  idx_a,
    input  logic [IDX_W-1:0]  idx_b,
    input  logic [IDX_W-1:0]  idx_c,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic              done,
    output logic [DATA_W-1:0] res
);

    route_t            route_in;
    route_t            route_q;
    logic [IDX_W-1:0]  ia_q, ib_q, ic_q;
    logic [DATA_W-1:0] da_q, db_q;
    logic [DATA_W-1:0] la, lb, sum;
    logic              exec, fire, we;

    assign route_in = make_route(ext_a, ext_b, keep_local);
    assign we       = fire && route_q.dst_local;

    ci_lrf_seq #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst(rst), .ce(ce), .start(start),
        .route_i(route_in), .ia_i(idx_a), .ib_i(idx_b), .ic_i(idx_c),
        .da_i(opnd_a), .db_i(opnd_b),
        .route_q(route_q), .ia_q(ia_q), .ib_q(ib_q), .ic_q(ic_q),
        .da_q(da_q), .db_q(db_q), .exec_o(exec), .fire_o(fire)
    );

    ci_lrf_bank #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_bank (
        .clk(clk), .rst(rst), .we(we), .waddr(ic_q), .wdata(sum),
        .ra(ia_q), .rb(ib_q), .rda(la), .rdb(lb)
    );

    ci_lrf_exec #(.DATA_W(DATA_W)) u_exec (
        .clk(clk), .rst(rst), .ce(ce), .fire(fire), .route(route_q),
        .da(da_q), .db(db_q), .la(la), .lb(lb),
        .sum(sum), .res_q(res), .done_q(done)
    );

    AST_DONE_AFTER_EXEC: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(exec)) else $error("done without execution"); // R10

endmodule

// File: tb/ci_lrf_unit_test.sv
`timescale 1ns/1ps
module ci_lrf_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce = 1'b1;
    logic        start = 1'b0;
    logic        ext_a = 1'b0, ext_b = 1'b0, keep_local = 1'b0;
    logic [4:0]  idx_a = '0, idx_b = '0, idx_c = '0;
    logic [31:0] opnd_a = '0, opnd_b = '0;
    logic        done;
    logic [31:0] res;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    ci_lrf_unit uut (
        .clk(clk), .rst(rst), .ce(ce), .start(start),
        .ext_a(ext_a), .ext_b(ext_b), .keep_local(keep_local),
        .idx_a(idx_a), .idx_b(idx_b), .idx_c(idx_c),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .done(done), .res(res)
    );

    // Behavioural reference model
    logic [31:0] m_rf [0:31];
    logic        m_busy, m_done;
    logic [31:0] m_res;
    logic        m_ea, m_eb, m_wb;
    logic [4:0]  m_ia, m_ib, m_ic;
    logic [31:0] m_da, m_db;

    always @(posedge clk) begin
        if (rst) begin
            m_busy <= 1'b0;
            m_done <= 1'b0;
            m_res  <= '0;
            for (int k = 0; k < 32; k++) m_rf[k] <= '0;
        end else if (ce) begin
            if (m_busy) begin
                logic [31:0] s;
                s = (m_ea ? m_da : m_rf[m_ia]) + (m_eb ? m_db : m_rf[m_ib]);
                if (m_wb) m_rf[m_ic] <= s;
                m_res  <= s;
                m_done <= 1'b1;
                m_busy <= 1'b0;
            end else begin
                m_done <= 1'b0;
                if (start) begin
                    m_busy <= 1'b1;
                    m_ea <= ext_a; m_eb <= ext_b; m_wb <= keep_local;
                    m_ia <= idx_a; m_ib <= idx_b; m_ic <= idx_c;
                    m_da <= opnd_a; m_db <= opnd_b;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model (R10 timing, R9 holding)
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk(done === m_done, "R10 done vs model", {31'd0, done}, {31'd0, m_done});
            chk(res === m_res, "R10 res vs model", res, m_res);
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    // Issue one instruction, scramble inputs during execution (R8).
    task automatic run_op(input logic ea, input logic eb, input logic wb,
                          input logic [4:0] ia, input logic [4:0] ib, input logic [4:0] ic,
                          input logic [31:0] da, input logic [31:0] db,
                          input logic [31:0] exp, input string tag);
        @(negedge clk);
        ce = 1'b1; start = 1'b1;
        ext_a = ea; ext_b = eb; keep_local = wb;
        idx_a = ia; idx_b = ib; idx_c = ic;
        opnd_a = da; opnd_b = db;
        @(negedge clk);
        start = 1'b0;
        ext_a = ~ea; ext_b = ~eb; keep_local = ~wb;
        idx_a = ia ^ 5'h1f; idx_b = ib ^ 5'h1f; idx_c = ic ^ 5'h1f;
        opnd_a = ~da; opnd_b = ~db;
        chk(done === 1'b0, "R10 done early", {31'd0, done}, 32'd0);
        @(negedge clk);
        chk(done === 1'b1, "R10 done pulse", {31'd0, done}, 32'd1);
        chk(res === exp, {tag, " R8 result"}, res, exp);
        @(negedge clk);
        chk(done === 1'b0, "R10 done one cycle", {31'd0, done}, 32'd0);
    endtask

    function automatic logic [31:0] ld(input int i);
        return 32'h1000 * i + i;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(done === 1'b0, "R1 done after reset", {31'd0, done}, 32'd0);
        chk(res === 32'd0, "R1 res after reset", res, 32'd0);

        // R1: every private register reads as zero
        for (int i = 0; i < 32; i++)
            run_op(1'b0, 1'b1, 1'b0, 5'(i), 5'd0, 5'd0, 32'd0, 32'd0, 32'd0, "R1");

        // R5: load bank with write-back; result still shows sum
        for (int i = 1; i < 32; i++)
            run_op(1'b1, 1'b1, 1'b1, 5'd0, 5'd0, 5'(i), 32'h1000 * i, 32'(i), ld(i), "R5");
        run_op(1'b0, 1'b1, 1'b0, 5'd12, 5'd0, 5'd0, 32'd0, 32'd0, ld(12), "R5 readback");

        // R2: both external
        run_op(1'b1, 1'b1, 1'b0, 5'd3, 5'd4, 5'd0, 32'h1234_5678, 32'h1111_1111, 32'h2345_6789, "R2");
        // R3: local A, external B
        run_op(1'b0, 1'b1, 1'b0, 5'd3, 5'd0, 5'd0, 32'd0, 32'd7, ld(3) + 32'd7, "R3");
        // R4: external A, local B
        run_op(1'b1, 1'b0, 1'b0, 5'd0, 5'd9, 5'd0, 32'd100, 32'd0, ld(9) + 32'd100, "R4");
        // R3/R4: both local
        run_op(1'b0, 1'b0, 1'b0, 5'd4, 5'd6, 5'd0, 32'd0, 32'd0, ld(4) + ld(6), "R4 both local");
        // R7: indices point at non-zero registers but flags select external
        run_op(1'b1, 1'b1, 1'b0, 5'd7, 5'd8, 5'd0, 32'd5, 32'd6, 32'd11, "R7");

        // R6: no write-back leaves register 10 intact
        run_op(1'b1, 1'b1, 1'b0, 5'd0, 5'd0, 5'd10, 32'd1, 32'd1, 32'd2, "R6");
        run_op(1'b0, 1'b1, 1'b0, 5'd10, 5'd0, 5'd0, 32'd0, 32'd0, ld(10), "R6 readback");

        // R11: same index read and written
        run_op(1'b0, 1'b1, 1'b1, 5'd5, 5'd0, 5'd5, 32'd0, 32'd1, ld(5) + 32'd1, "R11");
        run_op(1'b0, 1'b1, 1'b0, 5'd5, 5'd0, 5'd0, 32'd0, 32'd0, ld(5) + 32'd1, "R11 readback");

        // R10: wrap-around
        run_op(1'b1, 1'b1, 1'b0, 5'd0, 5'd0, 5'd0, 32'hFFFF_FFFF, 32'd2, 32'd1, "R10 wrap");

        // R9: start ignored while ce low
        @(negedge clk);
        ce = 1'b0; start = 1'b1; ext_a = 1'b1; ext_b = 1'b1; keep_local = 1'b1;
        idx_c = 5'd2; opnd_a = 32'd40; opnd_b = 32'd2;
        repeat (3) @(negedge clk);
        chk(done === 1'b0, "R9 no issue while ce low", {31'd0, done}, 32'd0);
        chk(res === 32'd1, "R9 res held", res, 32'd1);
        start = 1'b0; ce = 1'b1;
        repeat (2) @(negedge clk);
        chk(done === 1'b0, "R9 nothing started", {31'd0, done}, 32'd0);
        run_op(1'b0, 1'b1, 1'b0, 5'd2, 5'd0, 5'd0, 32'd0, 32'd0, ld(2), "R9 bank untouched");

        // R9: stall in mid-execution, then with done high
        @(negedge clk);
        start = 1'b1; ext_a = 1'b1; ext_b = 1'b1; keep_local = 1'b0;
        opnd_a = 32'd300; opnd_b = 32'd33;
        @(negedge clk);
        start = 1'b0; ce = 1'b0; opnd_a = 32'd0;
        repeat (3) @(negedge clk);
        chk(done === 1'b0, "R9 stalled exec", {31'd0, done}, 32'd0);
        ce = 1'b1;
        @(negedge clk);
        chk(done === 1'b1, "R9 done after stall", {31'd0, done}, 32'd1);
        chk(res === 32'd333, "R9 result after stall", res, 32'd333);
        ce = 1'b0;
        repeat (3) @(negedge clk);
        chk(done === 1'b1, "R9 done held while ce low", {31'd0, done}, 32'd1);
        ce = 1'b1;
        @(negedge clk);
        chk(done === 1'b0, "R10 done drops on enabled edge", {31'd0, done}, 32'd0);
        chk(res === 32'd333, "R10 res held after done", res, 32'd333);

        repeat (2) @(negedge clk);
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
            summary();
        end
    end

endmodule